// File: doc/BRIEF.md
# D and Echo Channel Bit Handler

This block performs the per-frame handling of the signalling (D) and echo (E) bits of a basic-rate S/T line transceiver. It can operate as either the network side or the terminal side. On the network side it rebuilds each transmitted echo bit from the most recently demodulated D bit, with a selectable polarity. It also drives the three multiframe bauds (Fa, M and S). These bauds are either held at zero or copied from a pattern that an external multiframe counter supplies.

On the terminal side the block decides what the D timeslot of the serial backplane output carries: the demodulated D bit or the demodulated echo bit. It also gates the D data that goes from the backplane to the line. Unless a bypass option is set, that data passes only while an external contention grant is asserted, and otherwise the line sees the idle value 1.

Every action happens on a single-cycle strobe from the framer. All outputs are registered and hold their value between strobes. The configuration is captured on a load strobe and cleared by either reset input.

Top module: `dech_bit_unit`

## Requirements
- R1: Configuration is captured from the cfg_* inputs on a cycle with `cfg_load` high. It takes effect from the next cycle. Both `rst` and `sw_rst` clear every configuration bit to 0, which means network role, no inversion, no echo mapping, no bypass and multiframing off.
- R2: Network role (`cfg_role_te`=0), `cfg_echo_inv`=0: `d_stb` stores `d_rx` as the previous D bit. One cycle after an `e_stb`, `e_tx` equals that stored bit.
- R3: Network role, `cfg_echo_inv`=1: one cycle after an `e_stb`, `e_tx` equals the inverse of the stored previous D bit.
- R4: When `d_stb` and `e_stb` coincide, `e_tx` is built from the D bit stored before that cycle. The new `d_rx` is used only by later echo strobes.
- R5: Terminal role, `cfg_map_echo`=0: one cycle after `d_stb`, `d_bp_out` equals `d_rx`.
- R6: Terminal role, `cfg_map_echo`=1: one cycle after `d_stb`, `d_bp_out` equals `e_rx`, and `d_rx` is discarded.
- R7: Terminal role, `cfg_bypass`=0: one cycle after `d_tx_stb`, `d_tx` equals `d_bp_in` if `grant` is 1, and 1 otherwise.
- R8: Terminal role, `cfg_bypass`=1: one cycle after `d_tx_stb`, `d_tx` equals `d_bp_in` whatever the value of `grant`.
- R9: Network role: one cycle after `mf_stb`, {`fa_tx`,`m_tx`,`s_tx`} equals `mf_pat[2:0]` if `cfg_mf_en` is 1, and 3'b000 otherwise.
- R10: Terminal role: one cycle after `mf_stb`, all three multiframe outputs are 0 whatever the value of `cfg_mf_en`.
- R11: After reset, `e_tx`, `d_tx` and `d_bp_out` are 1 and the multiframe outputs are 0. Every output holds its value in cycles without its strobe.
- R12: `e_tx` changes only in network role. `d_tx` and `d_bp_out` change only in terminal role. Each holds its value under strobes in the other role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| sw_rst | input | 1 | Synchronous software reset, active high |
| cfg_load | input | 1 | Capture the cfg_* inputs |
| cfg_role_te | input | 1 | 0 network side, 1 terminal side |
| cfg_echo_inv | input | 1 | Invert the transmitted echo bit |
| cfg_map_echo | input | 1 | Backplane D timeslot carries echo data |
| cfg_bypass | input | 1 | Ignore contention grant and echo |
| cfg_mf_en | input | 1 | Enable multiframe bauds |
| d_stb | input | 1 | Demodulated D bit valid |
| d_rx | input | 1 | Demodulated D bit |
| e_stb | input | 1 | Echo bit slot strobe |
| e_rx | input | 1 | Demodulated echo bit |
| d_tx_stb | input | 1 | Transmitted D bit slot strobe |
| d_bp_in | input | 1 | D bit from the backplane |
| grant | input | 1 | Contention grant |
| mf_stb | input | 1 | Multiframe baud slot strobe |
| mf_pat | input | 3 | Pattern {Fa, M, S} from the multiframe counter |
| e_tx | output | 1 | Transmitted echo bit |
| d_tx | output | 1 | D bit to the line |
| d_bp_out | output | 1 | D timeslot bit to the backplane |
| fa_tx | output | 1 | Fa baud |
| m_tx | output | 1 | M baud |
| s_tx | output | 1 | S baud |

## Verification
The echo builder reads the stored previous D bit in the same cycle in which a new D strobe may overwrite that bit. Coinciding `d_stb` and `e_stb` are therefore driven on purpose, with a new `d_rx` that differs from the stored bit. The echo must follow the older bit, and the following echo strobe must follow the newer one.

A configuration load that lands together with a datapath strobe is a second collision. The strobe must still be processed under the old configuration. The scoreboard model predicts both cases from the requirements, cycle by cycle, in directed sequences and in a long mixed run.

// File: rtl/dech_pkg.sv
package dech_pkg;

    typedef enum logic {
        ROLE_NT = 1'b0,
        ROLE_TE = 1'b1
    } role_e;

    typedef struct packed {
        role_e role;
        logic  echo_inv;
        logic  map_echo;
        logic  bypass;
        logic  mf_en;
    } cfg_t;

    typedef struct packed {
        logic fa;
        logic m;
        logic s;
    } mf_t;

    localparam int   MF_W      = $bits(mf_t);
    localparam logic IDLE_BIT  = 1'b1;
    localparam cfg_t CFG_CLEAR = '{role: ROLE_NT, echo_inv: 1'b0, map_echo: 1'b0,
                                   bypass: 1'b0, mf_en: 1'b0};
    localparam mf_t  MF_ZERO   = '{fa: 1'b0, m: 1'b0, s: 1'b0};

    function automatic logic echo_of(input logic d_prev, input logic inv);
        return d_prev ^ inv;
    endfunction

    function automatic logic contend(input logic byp, input logic gnt, input logic d);
        return (byp || gnt) ? d : IDLE_BIT;
    endfunction

    function automatic logic bp_slot(input logic map_e, input logic d, input logic e);
        return map_e ? e : d;
    endfunction

endpackage

// File: rtl/dech_cfg_reg.sv
module dech_cfg_reg
    import dech_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_rst,
    input  logic load,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            cfg_q <= CFG_CLEAR;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

    // R1
    sw_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> cfg_q == CFG_CLEAR);

    // R1
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst || sw_rst)
        load |=> cfg_q == $past(cfg_in));

endmodule

// File: rtl/dech_echo_nt.sv
module dech_echo_nt
    import dech_pkg::*;
(
    input  logic  clk,
    input  logic  clr,
    input  role_e role,
    input  logic  inv,
    input  logic  d_stb,
    input  logic  d_rx,
    input  logic  e_stb,
    output logic  e_tx
);

    logic d_prev_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            d_prev_q <= IDLE_BIT;
        end else if (d_stb) begin
            d_prev_q <= d_rx;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            e_tx <= IDLE_BIT;
        end else if (e_stb && role == ROLE_NT) begin
            e_tx <= echo_of(d_prev_q, inv);
        end
    end

    // R12
    echo_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (!e_stb || role == ROLE_TE) |=> $stable(e_tx));

    // R4
    echo_old_bit_chk: assert property (@(posedge clk) disable iff (clr)
        (e_stb && d_stb && role == ROLE_NT && !inv && d_rx != d_prev_q)
        |=> e_tx != $past(d_rx));

endmodule

// File: rtl/dech_te_path.sv
module dech_te_path
    import dech_pkg::*;
(
    input  logic  clk,
    input  logic  clr,
    input  role_e role,
    input  logic  map_echo,
    input  logic  bypass,
    input  logic  d_stb,
    input  logic  d_rx,
    input  logic  e_rx,
    input  logic  d_tx_stb,
    input  logic  d_bp_in,
    input  logic  grant,
    output logic  d_tx,
    output logic  d_bp_out
);

    logic te;
    assign te = (role == ROLE_TE);

    always_ff @(posedge clk) begin
        if (clr) begin
            d_bp_out <= IDLE_BIT;
        end else if (te && d_stb) begin
            d_bp_out <= bp_slot(map_echo, d_rx, e_rx);
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            d_tx <= IDLE_BIT;
        end else if (te && d_tx_stb) begin
            d_tx <= contend(bypass, grant, d_bp_in);
        end
    end

    // R7
    no_grant_idle_chk: assert property (@(posedge clk) disable iff (clr)
        (te && d_tx_stb && !bypass && !grant) |=> d_tx == IDLE_BIT);

    // R8
    bypass_pass_chk: assert property (@(posedge clk) disable iff (clr)
        (te && d_tx_stb && bypass) |=> d_tx == $past(d_bp_in));

    // R12
    te_hold_chk: assert property (@(posedge clk) disable iff (clr)
        !te |=> ($stable(d_tx) && $stable(d_bp_out)));

endmodule

// File: rtl/dech_mframe.sv
module dech_mframe
    import dech_pkg::*;
(
    input  logic            clk,
    input  logic            clr,
    input  role_e           role,
    input  logic            en,
    input  logic            mf_stb,
    input  logic [MF_W-1:0] mf_pat,
    output mf_t             mf_q
);

    logic drive_pat;
    assign drive_pat = (role == ROLE_NT) && en;

    always_ff @(posedge clk) begin
        if (clr) begin
            mf_q <= MF_ZERO;
        end else if (mf_stb) begin
            mf_q <= drive_pat ? mf_t'(mf_pat) : MF_ZERO;
        end
    end

    // R9
    mf_zero_chk: assert property (@(posedge clk) disable iff (clr)
        (mf_stb && !drive_pat) |=> mf_q == MF_ZERO);

    // R10
    mf_te_quiet_chk: assert property (@(posedge clk) disable iff (clr)
        (role == ROLE_TE) |=> $countones(mf_q) == 0 || $stable(mf_q));

endmodule

// File: rtl/dech_bit_unit.sv
module dech_bit_unit
    import dech_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_rst,
    input  logic       cfg_load,
    input  logic       cfg_role_te,
    input  logic       cfg_echo_inv,
    input  logic       cfg_map_echo,
    input  logic       cfg_bypass,
    input  logic       cfg_mf_en,
    input  logic       d_stb,
    input  logic       d_rx,
    input  logic       e_stb,
    input  logic       e_rx,
    input  logic       d_tx_stb,
    input  logic       d_bp_in,
    input  logic       grant,
    input  logic       mf_stb,
    input  logic [2:0] mf_pat,
    output logic       e_tx,
    output logic       d_tx,
    output logic       d_bp_out,
    output logic       fa_tx,
    output logic       m_tx,
    output logic       s_tx
);

    logic clr;
    cfg_t cfg_in;
    cfg_t cfg_q;
    mf_t  mf_q;

    assign clr    = rst || sw_rst;
    assign cfg_in = '{role: role_e'(cfg_role_te), echo_inv: cfg_echo_inv,
                      map_echo: cfg_map_echo, bypass: cfg_bypass, mf_en: cfg_mf_en};

    dech_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .sw_rst (sw_rst),
        .load   (cfg_load),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    dech_echo_nt u_echo (
        .clk   (clk),
        .clr   (clr),
        .role  (cfg_q.role),
        .inv   (cfg_q.echo_inv),
        .d_stb (d_stb),
        .d_rx  (d_rx),
        .e_stb (e_stb),
        .e_tx  (e_tx)
    );

    dech_te_path u_te (
        .clk      (clk),
        .clr      (clr),
        .role     (cfg_q.role),
        .map_echo (cfg_q.map_echo),
        .bypass   (cfg_q.bypass),
        .d_stb    (d_stb),
        .d_rx     (d_rx),
        .e_rx     (e_rx),
        .d_tx_stb (d_tx_stb),
        .d_bp_in  (d_bp_in),
        .grant    (grant),
        .d_tx     (d_tx),
        .d_bp_out (d_bp_out)
    );

    dech_mframe u_mf (
        .clk    (clk),
        .clr    (clr),
        .role   (cfg_q.role),
        .en     (cfg_q.mf_en),
        .mf_stb (mf_stb),
        .mf_pat (mf_pat),
        .mf_q   (mf_q)
    );

    assign fa_tx = mf_q.fa;
    assign m_tx  = mf_q.m;
    assign s_tx  = mf_q.s;

    // R11
    reset_out_chk: assert property (@(posedge clk) disable iff (1'b0)
        rst |=> (e_tx && d_tx && d_bp_out && !fa_tx && !m_tx && !s_tx));

endmodule

// File: tb/test_dech_bit_unit.sv
module test_dech_bit_unit;

    typedef struct packed {
        logic rst, swr, ld, te, inv, map, byp, mfen;
        logic ds, drx, es, erx, dts, dbp, gnt, ms;
        logic [2:0] pat;
    } stim_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, sw_rst = 1'b0, cfg_load = 1'b0;
    logic cfg_role_te = 1'b0, cfg_echo_inv = 1'b0, cfg_map_echo = 1'b0;
    logic cfg_bypass = 1'b0, cfg_mf_en = 1'b0;
    logic d_stb = 1'b0, d_rx = 1'b0, e_stb = 1'b0, e_rx = 1'b0;
    logic d_tx_stb = 1'b0, d_bp_in = 1'b0, grant = 1'b0, mf_stb = 1'b0;
    logic [2:0] mf_pat = 3'b000;
    logic e_tx, d_tx, d_bp_out, fa_tx, m_tx, s_tx;

    dech_bit_unit i_dech_bit_unit (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .cfg_load(cfg_load),
        .cfg_role_te(cfg_role_te), .cfg_echo_inv(cfg_echo_inv),
        .cfg_map_echo(cfg_map_echo), .cfg_bypass(cfg_bypass), .cfg_mf_en(cfg_mf_en),
        .d_stb(d_stb), .d_rx(d_rx), .e_stb(e_stb), .e_rx(e_rx),
        .d_tx_stb(d_tx_stb), .d_bp_in(d_bp_in), .grant(grant),
        .mf_stb(mf_stb), .mf_pat(mf_pat),
        .e_tx(e_tx), .d_tx(d_tx), .d_bp_out(d_bp_out),
        .fa_tx(fa_tx), .m_tx(m_tx), .s_tx(s_tx)
    );

    // scoreboard queues
    logic [5:0] exp_q[$];
    string      tag_q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model state, derived from the requirements
    logic c_te = 0, c_inv = 0, c_map = 0, c_byp = 0, c_mfen = 0;
    logic m_dprev = 1, m_e = 1, m_dtx = 1, m_bp = 1;
    logic [2:0] m_mf = 3'b000;

    task automatic go(input string tag, input stim_t s);
        @(negedge clk);
        #1;
        rst = s.rst; sw_rst = s.swr; cfg_load = s.ld;
        cfg_role_te = s.te; cfg_echo_inv = s.inv; cfg_map_echo = s.map;
        cfg_bypass = s.byp; cfg_mf_en = s.mfen;
        d_stb = s.ds; d_rx = s.drx; e_stb = s.es; e_rx = s.erx;
        d_tx_stb = s.dts; d_bp_in = s.dbp; grant = s.gnt;
        mf_stb = s.ms; mf_pat = s.pat;
        if (s.rst || s.swr) begin
            c_te = 0; c_inv = 0; c_map = 0; c_byp = 0; c_mfen = 0;
            m_dprev = 1; m_e = 1; m_dtx = 1; m_bp = 1; m_mf = 3'b000;
        end else begin
            if (!c_te && s.es) m_e = m_dprev ^ c_inv;
            if (s.ds) m_dprev = s.drx;
            if (c_te && s.ds) m_bp = c_map ? s.erx : s.drx;
            if (c_te && s.dts) m_dtx = (c_byp || s.gnt) ? s.dbp : 1'b1;
            if (s.ms) m_mf = (!c_te && c_mfen) ? s.pat : 3'b000;
            if (s.ld) begin
                c_te = s.te; c_inv = s.inv; c_map = s.map; c_byp = s.byp; c_mfen = s.mfen;
            end
        end
        exp_q.push_back({m_e, m_dtx, m_bp, m_mf});
        tag_q.push_back(tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0 && !done) begin
            logic [5:0] want;
            logic [5:0] got;
            string      t;
            want = exp_q.pop_front();
            t    = tag_q.pop_front();
            got  = {e_tx, d_tx, d_bp_out, fa_tx, m_tx, s_tx};
            n_chk++;
            if (got !== want) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b (e,dtx,bp,fa,m,s)", t, got, want);
            end
        end
    end

    function automatic stim_t cfg(input logic te, inv, map, byp, mfen);
        stim_t s = '0;
        s.ld = 1; s.te = te; s.inv = inv; s.map = map; s.byp = byp; s.mfen = mfen;
        return s;
    endfunction

    initial begin
        stim_t s;
        logic [15:0] lfsr = 16'hACE1;
        s = '0; s.rst = 1;
        go("R11", s); go("R11", s);
        s = '0; go("R11", s);
        go("R1", cfg(0, 0, 0, 0, 0)); s = '0; go("R1", s);
        // R2 echo follows stored D
        s = '0; s.ds = 1; s.drx = 0; go("R2", s);
        s = '0; s.es = 1; go("R2", s);
        s = '0; s.ds = 1; s.drx = 1; go("R2", s);
        s = '0; s.es = 1; go("R2", s);
        s = '0; go("R11", s); go("R11", s);
        // NT ignores D tx strobe
        s = '0; s.dts = 1; s.dbp = 0; s.gnt = 1; s.ds = 1; s.drx = 0; go("R12", s);
        // R3 inversion
        go("R3", cfg(0, 1, 0, 0, 0));
        s = '0; s.ds = 1; s.drx = 1; go("R3", s);
        s = '0; s.es = 1; go("R3", s);
        // R4 coincident strobes
        s = '0; s.ds = 1; s.drx = 0; s.es = 1; go("R4", s);
        s = '0; s.es = 1; go("R4", s);
        // R9 multiframe
        s = '0; s.ms = 1; s.pat = 3'b101; go("R9", s);
        go("R9", cfg(0, 0, 0, 0, 1));
        s = '0; s.ms = 1; s.pat = 3'b101; go("R9", s);
        s = '0; s.ms = 1; s.pat = 3'b010; go("R9", s);
        s = '0; go("R11", s);
        // config load coinciding with strobe uses old config
        s = cfg(1, 0, 0, 0, 0); s.es = 1; s.ms = 1; s.pat = 3'b111; go("R1", s);
        // R5/R6 backplane mapping, R12 echo holds in TE
        s = '0; s.ds = 1; s.drx = 0; s.erx = 1; go("R5", s);
        s = '0; s.es = 1; s.ds = 1; s.drx = 1; s.erx = 0; go("R12", s);
        go("R6", cfg(1, 0, 1, 0, 0));
        s = '0; s.ds = 1; s.drx = 0; s.erx = 1; go("R6", s);
        s = '0; s.ds = 1; s.drx = 1; s.erx = 0; go("R6", s);
        // R7 grant gating
        go("R7", cfg(1, 0, 0, 0, 0));
        s = '0; s.dts = 1; s.dbp = 0; s.gnt = 0; go("R7", s);
        s = '0; s.dts = 1; s.dbp = 0; s.gnt = 1; go("R7", s);
        s = '0; s.dts = 1; s.dbp = 0; s.gnt = 0; go("R7", s);
        // R8 bypass
        go("R8", cfg(1, 0, 0, 1, 0));
        s = '0; s.dts = 1; s.dbp = 0; s.gnt = 0; go("R8", s);
        s = '0; s.dts = 1; s.dbp = 1; s.gnt = 0; go("R8", s);
        s = '0; s.dts = 1; s.dbp = 0; s.gnt = 1; go("R8", s);
        // R10 multiframing in TE
        go("R10", cfg(1, 0, 0, 0, 1));
        s = '0; s.ms = 1; s.pat = 3'b111; go("R10", s);
        // R1 software reset clears config
        s = '0; s.swr = 1; go("R1", s);
        s = '0; s.ds = 1; s.drx = 0; go("R1", s);
        s = '0; s.es = 1; go("R1", s);
        s = '0; s.ms = 1; s.pat = 3'b111; go("R1", s);
        // mixed run
        for (int i = 0; i < 3000; i++) begin
            for (int k = 0; k < 3; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s = stim_t'({1'b0, 1'b0, lfsr[15:14] == 2'b00 && lfsr[3], lfsr[12:0], lfsr[15:13]});
            s.swr = (lfsr[11:4] == 8'h5A);
            go("MIX", s);
        end
        s = '0; go("R11", s);
        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule